// File: doc/BRIEF.md
# Linked-List Audio Route Walker

This block holds the route tables of a programmable audio interconnect and walks them on request. Every channel owns an entry word that holds the first hop of its route. Every routable block address owns a next-hop word. A route word carries a source address in its upper half and a destination address in its lower half. The destination of each hop is the index of the next-hop word that holds the following hop, so each channel's route forms a linked list. A word with every bit set ends the list.

Software fills both tables through a small write port. A walk request for a channel makes the block follow that channel's list at one table read per clock. It emits each source/destination pair with a valid strobe, in list order. It then signals the end of the walk, with the number of hops and, for a list that never ends, an error flag. Default addresses are 7 bits wide, so a route word is 14 bits and the end marker is 0x3FFF. The usual address map places DMA channels at 0x00-0x0F, rate converters at 0x10-0x1F, mixer outputs at 0x20-0x2F, mixer inputs at 0x30-0x3F, codec record at 0x48-0x49 and codec playback at 0x58-0x59. The walker gives no special meaning to any of these ranges.

Top module: `route_chain_walker`

## Requirements
- R1: A route word is 2*AW bits wide. The source address is bits [2*AW-1:AW] and appears on `hop_src`. The destination address is bits [AW-1:0] and appears on `hop_dst`.
- R2: `walk_req` is sampled high at a clock edge while `busy` is low, with `walk_ch` < NCH. At that edge `busy` rises. At the next edge, if entry word `walk_ch` is not the end marker, `hop_valid` pulses for one cycle with that word's fields.
- R3: After any hop with destination Y, the next hop is taken from next-hop word Y. Hops appear on consecutive cycles with `hop_valid` high, and `hop_count` increments by one with each hop.
- R4: A fetched word that is all ones ends the walk. One cycle after the last hop, `done` pulses for one cycle, `busy` falls in the same cycle, and `hop_count` equals the number of hops emitted.
- R5: If the entry word is already the end marker, `done` pulses one cycle after the request. In that case `hop_count` is 0 and `hop_valid` never rises.
- R6: The walk can reach 2**AW hops without finding the end marker. The walk then stops with `done` and `loop_err` high together. `loop_err` stays high until the next walk is accepted, and is cleared at that point.
- R7: `walk_req` is ignored while `busy` is high. The running walk continues unchanged, and no new walk starts after it ends.
- R8: A write is performed when `wr_en` is high and `wr_ready` is high at a clock edge. `wr_sel`=0 writes entry word `wr_addr`[CW-1:0], and `wr_sel`=1 writes next-hop word `wr_addr`. `wr_ready` is low while a walk is busy, and a write presented then is discarded.
- R9: Reset sets every table word to the end marker and clears `busy`, `done`, `hop_valid`, `loop_err` and `hop_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 = entry table, 1 = next-hop table |
| wr_addr | input | AW | Table index |
| wr_data | input | 2*AW | Route word to store |
| wr_ready | output | 1 | Writes are accepted |
| walk_req | input | 1 | Start a walk |
| walk_ch | input | CW | Channel to walk |
| busy | output | 1 | Walk in progress |
| hop_valid | output | 1 | Hop pair valid this cycle |
| hop_src | output | AW | Source address of the hop |
| hop_dst | output | AW | Destination address of the hop |
| done | output | 1 | One-cycle end-of-walk pulse |
| hop_count | output | AW+1 | Hops emitted by the current or last walk |
| loop_err | output | 1 | Last walk hit the hop limit |

## Verification
The hardest case to reach is a request and a table write arriving in the middle of a walk. Their effects show only later, once the walk has ended. The bench injects both on the second hop of a seven-hop chain. It checks that the chain comes out unchanged and that no second walk follows. A later walk of the targeted channel then shows that the write never landed. A self-looping next-hop word drives the hop limit and the error flag. A shared bench model of both tables predicts every hop.

// File: rtl/route_chain_walker.sv
module route_chain_walker #(
  parameter int AW  = 7,
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int WW = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          walk_req,
  input  logic [CW-1:0] walk_ch,
  output logic          busy,
  output logic          hop_valid,
  output logic [AW-1:0] hop_src,
  output logic [AW-1:0] hop_dst,
  output logic          done,
  output logic [AW:0]   hop_count,
  output logic          loop_err
);
  localparam int DEPTH = 1 << AW;
  localparam logic [WW-1:0] TERM = {WW{1'b1}};

  logic [WW-1:0] entry_q [NCH];
  logic [WW-1:0] next_q  [DEPTH];
  logic [WW-1:0] word_q;

  wire at_end   = (word_q == TERM);
  wire at_limit = (hop_count == (AW+1)'(DEPTH));

  assign wr_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) entry_q[i] <= TERM;
      for (int i = 0; i < DEPTH; i++) next_q[i] <= TERM;
      word_q    <= TERM;
      busy      <= 1'b0;
      hop_valid <= 1'b0;
      hop_src   <= '0;
      hop_dst   <= '0;
      done      <= 1'b0;
      hop_count <= '0;
      loop_err  <= 1'b0;
    end else begin
      hop_valid <= 1'b0;
      done      <= 1'b0;
      if (wr_en && !busy) begin
        if (wr_sel) next_q[wr_addr] <= wr_data;
        else        entry_q[wr_addr[CW-1:0]] <= wr_data;
      end
      if (!busy) begin
        if (walk_req) begin
          busy      <= 1'b1;
          word_q    <= entry_q[walk_ch];
          hop_count <= '0;
          loop_err  <= 1'b0;
        end
      end else if (at_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (at_limit) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        loop_err <= 1'b1;
      end else begin
        hop_valid <= 1'b1;
        hop_src   <= word_q[WW-1:AW];
        hop_dst   <= word_q[AW-1:0];
        hop_count <= hop_count + 1'b1;
        word_q    <= next_q[word_q[AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/route_chain_walker_chk.sv
module route_chain_walker_chk #(
  parameter int AW  = 7,
  parameter int NCH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_req,
  input logic        busy,
  input logic        hop_valid,
  input logic        done,
  input logic        loop_err,
  input logic [AW:0] hop_count
);
  localparam int DEPTH = 1 << AW;

  // R2
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(walk_req));

  // R3
  hop_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> busy);

  // R3
  hop_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> hop_count == (AW+1)'($past(hop_count) + 1'b1));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !hop_valid);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_err) |-> done);

  // R6
  hop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hop_count <= (AW+1)'(DEPTH));
endmodule

bind route_chain_walker route_chain_walker_chk #(.AW(AW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .busy(busy),
  .hop_valid(hop_valid), .done(done), .loop_err(loop_err), .hop_count(hop_count)
);

// File: tb/route_chain_walker_tb.sv
`timescale 1ns/1ps
module route_chain_walker_tb;
  localparam int AW = 7;
  localparam int NCH = 32;
  localparam int CW = $clog2(NCH);
  localparam int WW = 2 * AW;
  localparam int DEPTH = 1 << AW;
  localparam logic [WW-1:0] TERM = {WW{1'b1}};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic wr_ready, walk_req = 0, busy, hop_valid, done, loop_err;
  logic [CW-1:0] walk_ch = '0;
  logic [AW-1:0] hop_src, hop_dst;
  logic [AW:0] hop_count;

  always #2 clk = ~clk;

  route_chain_walker #(.AW(AW), .NCH(NCH)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [WW-1:0] sh_entry [NCH];
  logic [WW-1:0] sh_next [DEPTH];

  localparam logic [WW+AW:0] WR_VEC [13] = '{
    {1'b0, 7'h11, 14'h1031}, {1'b1, 7'h31, 14'h10B2}, {1'b1, 7'h32, 14'h1158},
    {1'b1, 7'h58, 14'h11D9}, {1'b1, 7'h59, 14'h2434}, {1'b1, 7'h34, 14'h24B3},
    {1'b1, 7'h33, 14'h0835}, {1'b0, 7'h02, 14'h0110}, {1'b1, 7'h10, 14'h0820},
    {1'b1, 7'h20, 14'h1048}, {1'b0, 7'h05, 14'h02BA}, {1'b1, 7'h3A, 14'h1D3A},
    {1'b0, 7'h1F, 14'h3FFE}};
  localparam int WALKS [5] = '{17, 2, 31, 0, 5};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input bit sel, input int addr, input int data);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R8 ready when idle", int'(wr_ready), 1);
    wr_en = 1; wr_sel = sel; wr_addr = AW'(addr); wr_data = WW'(data);
    if (sel) sh_next[addr] = WW'(data); else sh_entry[addr % NCH] = WW'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_walk(input int ch, input bit poke);
    logic [WW-1:0] cur;
    int k;
    cur = sh_entry[ch];
    k = 0;
    @(negedge clk);
    walk_req = 1; walk_ch = CW'(ch);
    @(negedge clk);
    walk_req = 0;
    forever begin
      @(negedge clk);
      if (poke && k == 2) begin walk_req = 0; wr_en = 0; end
      if (cur != TERM && k < DEPTH) begin
        chk(hop_valid == 1'b1, k == 0 ? "R2 first hop valid" : "R3 hop valid", int'(hop_valid), 1);
        chk(hop_src == cur[WW-1:AW], "R1 hop source", int'(hop_src), int'(cur[WW-1:AW]));
        chk(hop_dst == cur[AW-1:0], "R1 hop destination", int'(hop_dst), int'(cur[AW-1:0]));
        if (poke && k == 1) begin
          chk(wr_ready == 1'b0, "R8 not ready while busy", int'(wr_ready), 0);
          walk_req = 1; walk_ch = CW'(2);
          wr_en = 1; wr_sel = 0; wr_addr = '0; wr_data = 14'h0082;
        end
        cur = sh_next[cur[AW-1:0]];
        k++;
      end else begin
        chk(done == 1'b1, k == 0 ? "R5 done at once" : "R4 done", int'(done), 1);
        chk(busy == 1'b0, "R4 busy falls", int'(busy), 0);
        chk(hop_valid == 1'b0, "R4 no hop at done", int'(hop_valid), 0);
        chk(hop_count == (AW+1)'(k), "R4 hop count", int'(hop_count), k);
        chk(loop_err == (cur != TERM), "R6 loop error flag", int'(loop_err), int'(cur != TERM));
        break;
      end
    end
    if (poke) begin
      repeat (2) begin
        @(negedge clk);
        chk(busy == 1'b0 && hop_valid == 1'b0, "R7 request during walk ignored", int'(busy), 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) sh_entry[i] = TERM;
    for (int i = 0; i < DEPTH; i++) sh_next[i] = TERM;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(busy == 0, "R9 busy", int'(busy), 0);
    chk(done == 0 && hop_valid == 0, "R9 strobes", int'(done), 0);
    chk(loop_err == 0, "R9 loop_err", int'(loop_err), 0);
    chk(hop_count == 0, "R9 hop_count", int'(hop_count), 0);
    chk(wr_ready == 1, "R9 wr_ready", int'(wr_ready), 1);
    run_walk(17, 0);   // R9 tables reset to the end marker, R5

    for (int i = 0; i < 13; i++)
      do_write(WR_VEC[i][WW+AW], int'(WR_VEC[i][WW+AW-1:WW]), int'(WR_VEC[i][WW-1:0]));
    for (int i = 0; i < 5; i++) run_walk(WALKS[i], 0);

    // R6 error flag held after the looped walk, cleared by the next walk
    repeat (3) begin
      @(negedge clk);
      chk(loop_err == 1'b1, "R6 loop_err held", int'(loop_err), 1);
    end
    run_walk(2, 0);

    // R7 and R8: request and write injected mid-walk
    run_walk(17, 1);
    run_walk(0, 0);

    // R4 shorter chain after rewriting a next-hop word
    do_write(1, 'h32, TERM);
    run_walk(17, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule